// File: doc/BRIEF.md
# Serial Command Receiver for a Display Controller

This block is the host-facing serial slave of a vacuum-fluorescent display controller. A host frames each transfer by pulling chip select low and then clocks bytes in on a serial data line, least significant bit first, with an external serial clock. The first byte of a frame is a command. Three command kinds load configuration fields: display enable, digit count and duty; start digit; and one four-bit nibble of the general-purpose output groups. The fourth kind switches the rest of the frame into a data stream. In that stream every later byte is written into display RAM at an address that counts up from zero.

While the data stream runs, the block returns converter results on the serial output at the same time as it receives, one byte per received byte. The first returned byte is channel 0 and the channels follow in order. The serial output is enabled only while chip select is low. All three serial inputs go through a sampling filter in the system clock domain. The filter accepts a new level only when consecutive samples agree, so single-sample spikes on the serial clock cannot create bits.

The serial clock idles high. The host changes data after a falling edge, and the block samples on the rising edge. The converter bank is a plain input bus, one byte per channel.

Top module: `vfd_cmd_slave`

## Requirements
- R1: `sdo_oe` is 1 only while the filtered chip select is low. It is 0 during reset and within SMP+1 clock cycles after `cs_n` goes high.
- R2: Bits on `sdin` are taken on rising `sclk` edges, first bit into bit 0. The opcode of the first byte of a frame is its bits [7:5]: 111 stream, 110 state, 101 digit, 100 port.
- R3: Opcode 110 loads `disp_on` from bit 4, `digit_cnt` from bits [3:2] and `duty` from bits [1:0].
- R4: Opcode 101 loads `start_dig` from bits [3:0].
- R5: Opcode 100 with bit 4 = 0 loads `port_lo` from bits [3:0], and with bit 4 = 1 loads `port_hi`. The other group keeps its value.
- R6: A first byte with bit 7 = 0 changes nothing, and neither does any later byte of that frame. After an opcode of 110, 101 or 100, the remaining bytes of the frame are ignored.
- R7: After opcode 111, each later byte of the frame produces a one-cycle `ram_we` pulse with `ram_wdata` equal to the byte. `ram_addr` is 0 for the first byte and then rises by one per byte, wrapping modulo 2^AW. Every new opcode 111 restarts the address at 0.
- R8: During the k-th data byte after opcode 111 (k from 0), `sdo` carries channel k (bits [8k+7:8k] of `adc_bank`), bit 0 first, updated after each falling `sclk`. For k ≥ NCH, and during the command byte, `sdo` is 0.
- R9: If chip select rises before the eighth bit of a byte, the partial byte is dropped, no output changes, and the next frame starts from bit 0.
- R10: Each serial input changes its filtered level only after SMP consecutive equal samples. A low pulse on `sclk` one sample long produces no bit.
- R11: After reset, all configuration outputs and `ram_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling / system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, idles high |
| sdin | input | 1 | Serial data from host |
| adc_bank | input | 8*NCH | Converter results, channel c at bits [8c+7:8c] |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the serial output pad |
| disp_on | output | 1 | Display enable |
| digit_cnt | output | 2 | Digit count code |
| duty | output | 2 | Dimming duty code |
| start_dig | output | 4 | Start digit code |
| port_lo | output | 4 | Lower general-purpose output group |
| port_hi | output | 4 | Upper general-purpose output group |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | AW | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
The bench builds the block with NCH = 3, AW = 3 and SMP = 2. With three channels, the point where the returned bytes switch from channel data to zeros comes after a few data bytes. With an eight-entry address space, a ten-byte stream passes the address wrap. With these sizes every state, digit and port payload can be swept exhaustively, and so can all 128 invalid first bytes. The sampling depth of two also lets a one-clock `sclk` spike test the filter directly.

// File: rtl/vfd_cmd_pkg.sv
// Shared constants and types for the display-controller serial command receiver.
package vfd_cmd_pkg;

    // Opcode field (bits [7:5] of the first byte in a frame)
    localparam logic [2:0] OP_STREAM = 3'b111;
    localparam logic [2:0] OP_STATE  = 3'b110;
    localparam logic [2:0] OP_DIGIT  = 3'b101;
    localparam logic [2:0] OP_PORT   = 3'b100;

    // Where the current frame stands
    typedef enum logic [1:0] {
        FR_CMD  = 2'd0,   // expecting the command byte
        FR_DATA = 2'd1,   // every byte goes to display RAM
        FR_SKIP = 2'd2    // remaining bytes ignored until chip select rises
    } frame_t;

endpackage

// File: rtl/vfd_sample_filter.sv
// Sampling glitch filter, one lane per input bit.
// Each lane keeps the last SMP raw samples and moves its output only when all
// of them agree. Assumes SMP >= 2 and that inputs are asynchronous to clk.
// Latency from a clean input change to the output is SMP+1 clock edges.
module vfd_sample_filter #(
    parameter int             W       = 3,
    parameter int             SMP     = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic [SMP-1:0] hist;

        // Shift in raw samples and accept a level once the history is uniform
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist    <= {SMP{RST_VAL[i]}};
                dout[i] <= RST_VAL[i];
            end else begin
                hist <= {hist[SMP-2:0], din[i]};
                if (&hist) begin
                    dout[i] <= 1'b1;
                end else if (~|hist) begin
                    dout[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/vfd_rx_shift.sv
// Receive byte assembler.
// Shifts filtered serial data in on each rising serial-clock event, first bit
// into bit 0, and pulses byte_vld for one cycle when BW bits have arrived.
// Assumes frame_on drops whenever chip select is high; that clears the
// bit counter so a partial byte is thrown away.
module vfd_rx_shift #(
    parameter int BW = 8,
    localparam int CW = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_on,
    input  logic          sclk_rise,
    input  logic          sdin,
    output logic [CW-1:0] bit_idx,
    output logic          byte_vld,
    output logic [BW-1:0] byte_q
);

    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [BW-1:0] sr;

    // Assemble bits and flag completed bytes
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            sr       <= '0;
            bit_idx  <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (sclk_rise) begin
                sr <= {sdin, sr[BW-1:1]};
                if (bit_idx == LAST) begin
                    bit_idx  <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {sdin, sr[BW-1:1]};
                end else begin
                    bit_idx <= bit_idx + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vfd_tx_shift.sv
// Transmit shifter for converter results.
// While stream_on is high, the falling serial-clock event at the start of each
// byte (bit_idx == 0) loads the next channel; later falls shift right so sdo
// always shows bit 0 of the register. Channels past NCH return zero.
// Assumes stream_on rises before the first fall of the first data byte.
module vfd_tx_shift #(
    parameter int BW  = 8,
    parameter int NCH = 6,
    localparam int CW = $clog2(BW),
    localparam int IW = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_on,
    input  logic              sclk_fall,
    input  logic [CW-1:0]     bit_idx,
    input  logic [NCH*BW-1:0] adc_bank,
    output logic              sdo_bit
);

    localparam logic [IW-1:0] IDX_END = IW'(NCH);

    logic [IW-1:0] ch_idx;
    logic [BW-1:0] sr;
    logic [BW-1:0] ch_sel;

    // Pick the channel addressed by ch_idx, zero beyond the bank
    always_comb begin
        ch_sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(ch_idx) == c) begin
                ch_sel = adc_bank[c*BW +: BW];
            end
        end
    end

    // Load at byte start, shift on the remaining falls
    always_ff @(posedge clk) begin
        if (!rst_n || !stream_on) begin
            ch_idx <= '0;
            sr     <= '0;
        end else if (sclk_fall) begin
            if (bit_idx == '0) begin
                sr <= ch_sel;
                if (ch_idx != IDX_END) begin
                    ch_idx <= ch_idx + IW'(1);
                end
            end else begin
                sr <= {1'b0, sr[BW-1:1]};
            end
        end
    end

    assign sdo_bit = sr[0];

endmodule

// File: rtl/vfd_cmd_decode.sv
// Command parser and display RAM write port.
// The first byte of a frame selects an action by its top three bits; the
// stream opcode turns every later byte into a RAM write at an address that
// starts at zero. Assumes byte_vld pulses are many cycles apart.
module vfd_cmd_decode
    import vfd_cmd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_on,
    input  logic          byte_vld,
    input  logic [7:0]    byte_q,
    output logic          stream_on,
    output logic          disp_on,
    output logic [1:0]    digit_cnt,
    output logic [1:0]    duty,
    output logic [3:0]    start_dig,
    output logic [3:0]    port_lo,
    output logic [3:0]    port_hi,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata
);

    frame_t        st;
    logic [AW-1:0] wr_ptr;

    // Frame state, configuration fields and RAM write generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FR_CMD;
            wr_ptr    <= '0;
            disp_on   <= 1'b0;
            digit_cnt <= '0;
            duty      <= '0;
            start_dig <= '0;
            port_lo   <= '0;
            port_hi   <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= 1'b0;
            if (!frame_on) begin
                st <= FR_CMD;
            end else if (byte_vld) begin
                unique case (st)
                    FR_CMD: begin
                        st <= FR_SKIP;
                        case (byte_q[7:5])
                            OP_STREAM: begin
                                st     <= FR_DATA;
                                wr_ptr <= '0;
                            end
                            OP_STATE: begin
                                disp_on   <= byte_q[4];
                                digit_cnt <= byte_q[3:2];
                                duty      <= byte_q[1:0];
                            end
                            OP_DIGIT: start_dig <= byte_q[3:0];
                            OP_PORT: begin
                                if (byte_q[4]) port_hi <= byte_q[3:0];
                                else           port_lo <= byte_q[3:0];
                            end
                            default: ;
                        endcase
                    end
                    FR_DATA: begin
                        ram_we    <= 1'b1;
                        ram_addr  <= wr_ptr;
                        ram_wdata <= byte_q;
                        wr_ptr    <= wr_ptr + AW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign stream_on = (st == FR_DATA);

endmodule

// File: rtl/vfd_cmd_slave.sv
// Top of the display-controller serial command receiver.
// Filters the three serial inputs in the clk domain, detects serial-clock
// edges, assembles bytes, decodes commands and returns converter bytes.
// Assumes each serial-clock phase lasts longer than SMP+3 clk cycles.
module vfd_cmd_slave #(
    parameter int NCH = 6,
    parameter int AW  = 5,
    parameter int SMP = 2,
    localparam int BW = 8,
    localparam int CW = $clog2(BW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic [NCH*BW-1:0] adc_bank,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              disp_on,
    output logic [1:0]        digit_cnt,
    output logic [1:0]        duty,
    output logic [3:0]        start_dig,
    output logic [3:0]        port_lo,
    output logic [3:0]        port_hi,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [BW-1:0]     ram_wdata
);

    logic          cs_flt;
    logic          sclk_flt;
    logic          sdin_flt;
    logic          sclk_q;
    logic          sclk_rise;
    logic          sclk_fall;
    logic          frame_on;
    logic          stream_on;
    logic          byte_vld;
    logic [BW-1:0] byte_q;
    logic [CW-1:0] bit_idx;
    logic          sdo_bit;

    vfd_sample_filter #(
        .W       (3),
        .SMP     (SMP),
        .RST_VAL (3'b110)
    ) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdin}),
        .dout  ({cs_flt, sclk_flt, sdin_flt})
    );

    // Remember the previous filtered serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_flt;
    end

    assign sclk_rise = sclk_flt & ~sclk_q;
    assign sclk_fall = ~sclk_flt & sclk_q;
    assign frame_on  = ~cs_flt;

    vfd_rx_shift #(.BW(BW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_on  (frame_on),
        .sclk_rise (sclk_rise),
        .sdin      (sdin_flt),
        .bit_idx   (bit_idx),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q)
    );

    vfd_cmd_decode #(.AW(AW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_on  (frame_on),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .stream_on (stream_on),
        .disp_on   (disp_on),
        .digit_cnt (digit_cnt),
        .duty      (duty),
        .start_dig (start_dig),
        .port_lo   (port_lo),
        .port_hi   (port_hi),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    vfd_tx_shift #(.BW(BW), .NCH(NCH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stream_on (stream_on),
        .sclk_fall (sclk_fall),
        .bit_idx   (bit_idx),
        .adc_bank  (adc_bank),
        .sdo_bit   (sdo_bit)
    );

    assign sdo    = sdo_bit;
    assign sdo_oe = rst_n & frame_on;

endmodule

// File: rtl/vfd_cmd_slave_chk.sv
// Property checker for vfd_cmd_slave, attached with bind below.
// Watches chip select, the filtered chip select, the output enable, the RAM
// write port and the configuration fields.
module vfd_cmd_slave_chk #(
    parameter int AW  = 5,
    parameter int SMP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          cs_f,
    input logic          sdo_oe,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [16:0]   cfg
);

    localparam int HW = $clog2(SMP + 2);
    localparam logic [HW-1:0] HI_LIM = HW'(SMP + 1);

    logic [HW-1:0] hi_cnt;
    logic          seen_wr;
    logic [AW-1:0] last_addr;

    // Count consecutive clocks with raw chip select high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n) hi_cnt <= '0;
        else if (hi_cnt != HI_LIM) hi_cnt <= hi_cnt + HW'(1);
    end

    // Remember the previous write address inside the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || cs_f) begin
            seen_wr   <= 1'b0;
            last_addr <= '0;
        end else if (ram_we) begin
            seen_wr   <= 1'b1;
            last_addr <= ram_addr;
        end
    end

    AST_SDO_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == HI_LIM) |-> !sdo_oe);                                // R1
    AST_CFG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_f) |-> $stable(cfg));                                  // R9
    AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !$past(cs_f));                                       // R7
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);                                            // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && seen_wr) |-> (ram_addr == last_addr + AW'(1)));      // R7

endmodule

bind vfd_cmd_slave vfd_cmd_slave_chk #(.AW(AW), .SMP(SMP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cs_f     (cs_flt),
    .sdo_oe   (sdo_oe),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .cfg      ({disp_on, digit_cnt, duty, start_dig, port_lo, port_hi})
);

// File: tb/sim_vfd_cmd_slave.sv
`timescale 1ns/1ps
module sim_vfd_cmd_slave;

    localparam int NCH  = 3;
    localparam int AW   = 3;
    localparam int SMP  = 2;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic          sdin = 1'b0;
    logic [23:0]   adc_bank = 24'h963CA5;
    logic          sdo, sdo_oe, disp_on, ram_we;
    logic [1:0]    digit_cnt, duty;
    logic [3:0]    start_dig, port_lo, port_hi;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;

    int total = 0;
    int bad   = 0;
    int nw    = 0;
    logic [AW-1:0] wa [64];
    logic [7:0]    wd [64];

    // model of the configuration fields
    logic [4:0] m_state = '0;
    logic [3:0] m_dig = '0, m_lo = '0, m_hi = '0;

    always #2 clk = ~clk;

    vfd_cmd_slave #(.NCH(NCH), .AW(AW), .SMP(SMP)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .adc_bank(adc_bank), .sdo(sdo), .sdo_oe(sdo_oe), .disp_on(disp_on),
        .digit_cnt(digit_cnt), .duty(duty), .start_dig(start_dig),
        .port_lo(port_lo), .port_hi(port_hi), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // capture RAM writes away from the active edge
    always @(negedge clk) begin
        if (ram_we && nw < 64) begin
            wa[nw] = ram_addr;
            wd[nw] = ram_wdata;
            nw++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic o);
        sclk = 1'b0;
        sdin = b;
        wait_clk(HALF);
        o = sdo;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] o);
        for (int i = 0; i < 8; i++) xfer_bit(b[i], o[i]);
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic one_cmd(input logic [7:0] b);
        logic [7:0] o;
        frame_begin();
        xfer_byte(b, o);
        frame_end();
    endtask

    task automatic chk_cfg(input string req);
        chk({disp_on, digit_cnt, duty} == m_state, req, {disp_on, digit_cnt, duty}, m_state);
        chk(start_dig == m_dig, req, start_dig, m_dig);
        chk(port_lo == m_lo, req, port_lo, m_lo);
        chk(port_hi == m_hi, req, port_hi, m_hi);
    endtask

    task automatic stream(input int nbytes, input int seed);
        logic [7:0] o, d, e;
        nw = 0;
        frame_begin();
        xfer_byte(8'b111_00000, o);
        chk(o == 8'h00, "R8 cmd byte sdo", o, 0);
        for (int k = 0; k < nbytes; k++) begin
            d = 8'((k * 37 + seed) & 255);
            xfer_byte(d, o);
            e = (k < NCH) ? adc_bank[k*8 +: 8] : 8'h00;
            chk(o == e, "R8 returned byte", o, e);
        end
        frame_end();
        chk(nw == nbytes, "R7 write count", nw, nbytes);
        for (int k = 0; k < nbytes && k < 64; k++) begin
            d = 8'((k * 37 + seed) & 255);
            chk(wa[k] == AW'(k), "R7 write addr", wa[k], k % (1 << AW));
            chk(wd[k] == d, "R7 write data", wd[k], d);
        end
    endtask

    // watchdog
    initial begin
        #(4 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] o;
        wait_clk(5);
        // R11, R1: reset state
        chk(sdo_oe == 1'b0, "R1 oe in reset", sdo_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk_cfg("R11 reset cfg");
        chk(ram_we == 1'b0, "R11 reset we", ram_we, 0);
        chk(sdo_oe == 1'b0, "R1 oe idle", sdo_oe, 0);

        // R1: enable follows chip select
        frame_begin();
        chk(sdo_oe == 1'b1, "R1 oe in frame", sdo_oe, 1);
        frame_end();
        chk(sdo_oe == 1'b0, "R1 oe after frame", sdo_oe, 0);

        // R2, R3: every state payload
        for (int v = 0; v < 32; v++) begin
            one_cmd({3'b110, 5'(v)});
            m_state = 5'(v);
            chk_cfg("R3 state sweep");
        end

        // R4: every start digit
        for (int v = 0; v < 16; v++) begin
            one_cmd({3'b101, 1'b0, 4'(v)});
            m_dig = 4'(v);
            chk_cfg("R4 digit sweep");
        end

        // R5: both groups, every nibble
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 16; v++) begin
                one_cmd({3'b100, 1'(s), 4'(v ^ (s * 5))});
                if (s == 1) m_hi = 4'(v ^ 5);
                else        m_lo = 4'(v);
                chk_cfg("R5 port sweep");
            end
        end

        // R6: invalid first byte, then a valid-looking byte in the same frame
        for (int b = 0; b < 128; b++) begin
            frame_begin();
            xfer_byte(8'(b), o);
            xfer_byte({3'b110, ~m_state}, o);
            frame_end();
            chk_cfg("R6 invalid opcode");
        end

        // R6: bytes after a completed configuration command are ignored
        frame_begin();
        xfer_byte(8'b110_10110, o);
        xfer_byte(8'b110_01001, o);
        xfer_byte(8'b101_0_0111, o);
        frame_end();
        m_state = 5'b10110;
        chk_cfg("R6 trailing bytes");

        // R9: partial byte aborted by chip select
        frame_begin();
        for (int i = 0; i < 5; i++) xfer_bit(1'b1, o[0]);
        frame_end();
        chk_cfg("R9 partial byte");
        one_cmd(8'b100_1_1010);
        m_hi = 4'b1010;
        chk_cfg("R9 next frame aligned");

        // R10: one-sample spike on sclk yields no bit
        frame_begin();
        sclk = 1'b0;
        wait_clk(1);
        sclk = 1'b1;
        wait_clk(HALF);
        xfer_byte(8'b101_0_1001, o);
        frame_end();
        m_dig = 4'b1001;
        chk_cfg("R10 sclk spike");

        // R7, R8: data stream past the channel count and the address wrap
        stream(10, 5);
        // R7: address restarts on a new stream command
        stream(2, 99);
        chk_cfg("R7 cfg untouched by stream");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule